// File: doc/BRIEF.md
# Dual-Channel DAC Test Pattern Player

The player feeds a two-channel digital-to-analog converter under test with a looping test record. A record of programmable length is held in an on-chip pattern store. Both channels read that same record, so one stored waveform can drive an in-phase and a quadrature channel. The second channel reads it from a programmable starting position, which gives a fixed relative phase between the two outputs. Each code passes through a signed, saturating offset adder before it reaches the converter pins.

In place of stored data, a DC source can play a single static level. It can also play a level that alternates with zero from sample to sample. All settings are written through a narrow register write port into a shadow copy. The shadow copy becomes active when playback starts and again each time channel A finishes a record. A setting therefore never changes in the middle of a record.

Top module: `dac_pattern_player`

## Requirements
- R1: Both channels are 16 bits wide. The third clock edge after the edge that sets the enable bit drives `smp_valid` high. It stays high on every cycle while playback is enabled. The second edge after the edge that clears the enable bit drives it low.
- R2: At each start of playback, channel A begins at record position 0. On the same sample, channel B begins at its phase position.
- R3: After position L-1 of a record of length L, each channel reads position 0 next, and the record repeats without a gap.
- R4: A written record length is rounded down to a multiple of 256. A value that rounds to 0, or that exceeds the store depth (1024 by default), is ignored and the previous length is kept. The length after reset is 256.
- R5: A signed 16-bit two's-complement offset is added to every code. The result saturates at 0 and at 65535 instead of wrapping.
- R6: In static DC mode, both channels play the programmed DC level plus the offset on every sample.
- R7: In alternating DC mode, a channel plays the DC level at even record positions and zero at odd positions. The offset is added in both cases, and the parity is taken from each channel's own position.
- R8: Channel B reads position (n + P mod L) mod L, where P is the programmed phase and n is channel A's position.
- R9: A setting written during playback (length, offset, DC level, phase or mode) takes effect at the first sample of the next record of channel A. Every sample before that uses the old setting.
- R10: The register map works on word address `cfg_addr` with a 32-bit `cfg_wdata`:
  - 0 is control: bit 0 is enable, bit 1 selects DC mode, and bit 2 selects alternation.
  - 1 is the record length.
  - 2 is the offset, in bits 15:0.
  - 3 is the DC level, in bits 15:0.
  - 4 is the phase, in bits 9:0.
  - 5 writes the pattern store, with the address in bits 31:16 and the code in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| smp_a | output | 16 | Channel A code |
| smp_b | output | 16 | Channel B code |
| smp_valid | output | 1 | High on every sample cycle of playback |

## Verification
The first sample of a run appears three edges after the enabling write: one edge loads the pointers, one reads the store, and one registers the saturated sum. The bench waits exactly those three edges and then checks one sample at every following falling edge. It indexes its expectations by the sample count from that point. When a setting is written during a run, the write lands two positions ahead of the sample just checked, well before the record end. The bench therefore switches its model at sample L and not earlier. After a disable write, `smp_valid` is checked on the falling edge after the second rising edge.

// File: rtl/pp_pkg.sv
package pp_pkg;

   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_LEN   = 3'd1,
      REG_OFS   = 3'd2,
      REG_DCV   = 3'd3,
      REG_PHASE = 3'd4,
      REG_MEM   = 3'd5
   } reg_e;

   typedef struct packed {
      logic dc;
      logic alt;
   } src_mode_t;

endpackage

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
   import pp_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 1024,
   parameter int BLOCK    = 256,
   parameter int ADDR_W   = 10,
   parameter int LEN_W    = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [2:0]          addr,
   input  logic [31:0]         wdata,
   output logic                en,
   output src_mode_t           mode_sh,
   output logic [LEN_W-1:0]    len_sh,
   output logic [SAMPLE_W-1:0] ofs_sh,
   output logic [SAMPLE_W-1:0] dcv_sh,
   output logic [ADDR_W-1:0]   phase_sh,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_waddr,
   output logic [SAMPLE_W-1:0] mem_wdata
);

   logic [31:0] len_rnd;
   logic        len_ok;

   // round down to the granule, refuse zero and anything past the store
   assign len_rnd = wdata & 32'(~(BLOCK - 1));
   assign len_ok  = (len_rnd != 32'd0) && (len_rnd <= 32'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= 1'b0;
         mode_sh  <= '0;
         len_sh   <= LEN_W'(BLOCK);
         ofs_sh   <= '0;
         dcv_sh   <= '0;
         phase_sh <= '0;
      end else if (we) begin
         case (addr)
            REG_CTRL: begin
               en          <= wdata[0];
               mode_sh.dc  <= wdata[1];
               mode_sh.alt <= wdata[2];
            end
            REG_LEN:   if (len_ok) len_sh <= len_rnd[LEN_W-1:0];
            REG_OFS:   ofs_sh   <= wdata[SAMPLE_W-1:0];
            REG_DCV:   dcv_sh   <= wdata[SAMPLE_W-1:0];
            REG_PHASE: phase_sh <= wdata[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   assign mem_we    = we && (addr == REG_MEM);
   assign mem_waddr = wdata[16 +: ADDR_W];
   assign mem_wdata = wdata[SAMPLE_W-1:0];

endmodule

// File: rtl/pp_pattern_ram.sv
module pp_pattern_ram #(
   parameter int W      = 16,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 10,
   parameter int NRD    = 2
) (
   input  logic                  clk,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     waddr,
   input  logic [W-1:0]          wdata,
   input  logic                  rd_en,
   input  logic [NRD*ADDR_W-1:0] rd_addr,
   output logic [NRD*W-1:0]      rd_data
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar i = 0; i < NRD; i++) begin : g_rd
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (rd_en) q <= mem[rd_addr[i*ADDR_W +: ADDR_W]];
      end
      assign rd_data[i*W +: W] = q;
   end

endmodule

// File: rtl/pp_addr_walker.sv
module pp_addr_walker #(
   parameter int ADDR_W = 10,
   parameter int LEN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic [LEN_W-1:0]  len,
   output logic [ADDR_W-1:0] ptr
);

   logic last;
   assign last = ({1'b0, ptr} == (len - LEN_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr <= '0;
      else if (load)   ptr <= load_val;
      else if (step)   ptr <= last ? '0 : ptr + ADDR_W'(1);
   end

endmodule

// File: rtl/pp_out_lane.sv
module pp_out_lane
   import pp_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic                par,
   input  src_mode_t           mode,
   input  logic [SAMPLE_W-1:0] ofs,
   input  logic [SAMPLE_W-1:0] dcv,
   input  logic [SAMPLE_W-1:0] mem_q,
   input  logic                out_en,
   output logic [SAMPLE_W-1:0] smp
);

   localparam logic signed [SAMPLE_W+1:0] SMAX = {2'b00, {SAMPLE_W{1'b1}}};

   // controls travel alongside the store read so a record edge stays clean
   logic                par_q;
   src_mode_t           mode_q;
   logic [SAMPLE_W-1:0] ofs_q;
   logic [SAMPLE_W-1:0] dcv_q;
   logic [SAMPLE_W-1:0] src;
   logic signed [SAMPLE_W+1:0] sum;
   logic [SAMPLE_W-1:0] sat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_q  <= 1'b0;
         mode_q <= '0;
         ofs_q  <= '0;
         dcv_q  <= '0;
      end else if (cap) begin
         par_q  <= par;
         mode_q <= mode;
         ofs_q  <= ofs;
         dcv_q  <= dcv;
      end
   end

   always_comb begin
      if (!mode_q.dc)                src = mem_q;
      else if (mode_q.alt && par_q)  src = '0;
      else                           src = dcv_q;
      sum = $signed({2'b00, src}) + $signed({{2{ofs_q[SAMPLE_W-1]}}, ofs_q});
      if (sum < 0)          sat = '0;
      else if (sum > SMAX)  sat = {SAMPLE_W{1'b1}};
      else                  sat = sum[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      smp <= '0;
      else if (out_en) smp <= sat;
   end

endmodule

// File: rtl/dac_pattern_player.sv
module dac_pattern_player
   import pp_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 1024,
   parameter int BLOCK    = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [2:0]          cfg_addr,
   input  logic [31:0]         cfg_wdata,
   output logic [SAMPLE_W-1:0] smp_a,
   output logic [SAMPLE_W-1:0] smp_b,
   output logic                smp_valid
);

   localparam int ADDR_W  = $clog2(DEPTH);
   localparam int LEN_W   = ADDR_W + 1;
   localparam int MAX_SUB = DEPTH / BLOCK;
   localparam int NCH     = 2;

   initial begin : param_checks
      assert (SAMPLE_W >= 2 && SAMPLE_W <= 16) else $error("SAMPLE_W out of range");
      assert (BLOCK >= 2 && (BLOCK & (BLOCK - 1)) == 0) else $error("BLOCK not a power of two");
      assert (DEPTH >= BLOCK && (DEPTH % BLOCK) == 0) else $error("DEPTH not a multiple of BLOCK");
      assert ((1 << ADDR_W) == DEPTH) else $error("DEPTH not a power of two");
      assert (ADDR_W <= 16) else $error("store too deep for write port");
   end

   // shadow configuration
   logic                en;
   src_mode_t           mode_sh;
   logic [LEN_W-1:0]    len_sh;
   logic [SAMPLE_W-1:0] ofs_sh, dcv_sh;
   logic [ADDR_W-1:0]   phase_sh;
   logic                mem_we;
   logic [ADDR_W-1:0]   mem_waddr;
   logic [SAMPLE_W-1:0] mem_wdata;

   pp_cfg_regs #(
      .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .BLOCK(BLOCK),
      .ADDR_W(ADDR_W), .LEN_W(LEN_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .en(en), .mode_sh(mode_sh), .len_sh(len_sh), .ofs_sh(ofs_sh),
      .dcv_sh(dcv_sh), .phase_sh(phase_sh),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
   );

   // active configuration, refreshed only at a start or a record edge
   src_mode_t           act_mode;
   logic [LEN_W-1:0]    act_len;
   logic [SAMPLE_W-1:0] act_ofs, act_dcv;
   logic                run, s1v;
   logic                start, wrap, reload;
   logic [ADDR_W-1:0]   ptr      [NCH];
   logic [ADDR_W-1:0]   load_val [NCH];
   logic [ADDR_W-1:0]   phase_mod;

   function automatic logic [ADDR_W-1:0] fold_phase(input logic [ADDR_W-1:0] ph,
                                                    input logic [LEN_W-1:0]  len);
      logic [LEN_W-1:0] p;
      p = {1'b0, ph};
      for (int i = 0; i < MAX_SUB; i++) begin
         if (p >= len) p = p - len;
      end
      return p[ADDR_W-1:0];
   endfunction

   assign phase_mod = fold_phase(phase_sh, len_sh);
   assign start     = en && !run;
   assign wrap      = run && ({1'b0, ptr[0]} == (act_len - LEN_W'(1)));
   assign reload    = start || wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run       <= 1'b0;
         s1v       <= 1'b0;
         smp_valid <= 1'b0;
         act_mode  <= '0;
         act_len   <= LEN_W'(BLOCK);
         act_ofs   <= '0;
         act_dcv   <= '0;
      end else begin
         run       <= en;
         s1v       <= run && en;
         smp_valid <= s1v;
         if (reload) begin
            act_mode <= mode_sh;
            act_len  <= len_sh;
            act_ofs  <= ofs_sh;
            act_dcv  <= dcv_sh;
         end
      end
   end

   logic [NCH*ADDR_W-1:0]   rd_addr;
   logic [NCH*SAMPLE_W-1:0] rd_data;
   logic [SAMPLE_W-1:0]     lane_out [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      if (c == 0) begin : g_ref
         assign load_val[c] = '0;
      end else begin : g_shift
         assign load_val[c] = phase_mod;
      end

      pp_addr_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
         .clk(clk), .rst_n(rst_n), .load(reload), .load_val(load_val[c]),
         .step(run), .len(act_len), .ptr(ptr[c])
      );

      assign rd_addr[c*ADDR_W +: ADDR_W] = ptr[c];

      pp_out_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .cap(run), .par(ptr[c][0]),
         .mode(act_mode), .ofs(act_ofs), .dcv(act_dcv),
         .mem_q(rd_data[c*SAMPLE_W +: SAMPLE_W]),
         .out_en(s1v), .smp(lane_out[c])
      );
   end

   pp_pattern_ram #(.W(SAMPLE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .NRD(NCH)) u_ram (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .rd_en(run), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assign smp_a = lane_out[0];
   assign smp_b = lane_out[1];

endmodule

// File: rtl/pp_player_chk.sv
module pp_player_chk #(
   parameter int ADDR_W = 10,
   parameter int LEN_W  = 11,
   parameter int BLOCK  = 256,
   parameter int DEPTH  = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              reload,
   input logic [ADDR_W-1:0] ptr_a,
   input logic [ADDR_W-1:0] ptr_b,
   input logic [LEN_W-1:0]  act_len,
   input logic              smp_valid
);

   localparam int GB = $clog2(BLOCK);

   logic [LEN_W-1:0] gap;
   assign gap = (ptr_b >= ptr_a) ? LEN_W'(ptr_b - ptr_a)
                                 : LEN_W'(ptr_b) + act_len - LEN_W'(ptr_a);

   // R1: valid is gone one edge after the run flag falls
   p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |=> !smp_valid);

   // R2: every run starts channel A at position zero
   p_start_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> ptr_a == '0);

   // R3: pointers never leave the active record
   p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ({1'b0, ptr_a} < act_len) && ({1'b0, ptr_b} < act_len));

   // R4: the active length is a nonzero granule multiple within the store
   p_len_granule_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act_len[GB-1:0] == '0 && act_len != '0 && act_len <= LEN_W'(DEPTH));

   // R8: the distance between the channels holds inside a record
   p_phase_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$past(reload) |-> $stable(gap));

   // R9: the active length moves only on a reload
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run && !reload |=> $stable(act_len));

endmodule

bind dac_pattern_player pp_player_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLOCK(BLOCK), .DEPTH(DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
   .ptr_a(ptr[0]), .ptr_b(ptr[1]), .act_len(act_len), .smp_valid(smp_valid)
);

// File: tb/sim_dac_pattern_player.sv
`timescale 1ns/1ps
module sim_dac_pattern_player;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [15:0] smp_a, smp_b;
   logic        smp_valid;

   int checks = 0;
   int errors = 0;
   int img [1024];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dac_pattern_player u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .smp_a(smp_a), .smp_b(smp_b), .smp_valid(smp_valid)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic memw(input int a, input int v);
      wr(5, (a << 16) | (v & 16'hFFFF));
      img[a] = v & 16'hFFFF;
   endtask

   function automatic int model(input int pos, input int ofs, input bit dc,
                                input bit alt, input int dcv);
      int s;
      s = dc ? ((alt && (pos % 2 == 1)) ? 0 : dcv) : img[pos];
      s = s + ofs;
      if (s < 0) s = 0;
      if (s > 65535) s = 65535;
      return s;
   endfunction

   task automatic setup(input int len, input int ofs, input int ph, input int dcv);
      wr(1, len); wr(2, ofs & 16'hFFFF); wr(4, ph); wr(3, dcv);
   endtask

   // enable, wait the three-edge latency, then check count samples
   task automatic play(input string req, input int count, input int len, input int ofs,
                       input int ph, input bit dc, input bit alt, input int dcv);
      int pm = ph % len;
      wr(0, 1 | (dc ? 2 : 0) | (alt ? 4 : 0));
      repeat (3) @(posedge clk);
      for (int n = 0; n < count; n++) begin
         @(negedge clk);
         chk(req, "valid", int'(smp_valid), 1);
         chk(req, "chA", int'(smp_a), model(n % len, ofs, dc, alt, dcv));
         chk(req, "chB", int'(smp_b), model((n + pm) % len, ofs, dc, alt, dcv));
      end
      wr(0, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1", "valid after disable", int'(smp_valid), 0);
   endtask

   task automatic t_reset();
      chk("R1", "reset valid", int'(smp_valid), 0);
      chk("R1", "reset chA", int'(smp_a), 0);
      chk("R1", "reset chB", int'(smp_b), 0);
   endtask

   task automatic t_basic();
      // R10 register map, R2 start alignment, R3 wrap after 255
      setup(256, 0, 0, 0);
      play("R3", 300, 256, 0, 0, 1'b0, 1'b0, 0);
      play("R10", 4, 256, 0, 0, 1'b0, 1'b0, 0);
   endtask

   task automatic t_phase();
      setup(256, 0, 7, 0);
      play("R2", 20, 256, 0, 7, 1'b0, 1'b0, 0);
      setup(256, 0, 300, 0);
      play("R8", 270, 256, 0, 300, 1'b0, 1'b0, 0);
   endtask

   task automatic t_length();
      setup(700, 0, 5, 0);   // rounds to 512
      wr(1, 100);            // rounds to zero, ignored
      wr(1, 5000);           // past the store, ignored
      play("R4", 530, 512, 0, 5, 1'b0, 1'b0, 0);
   endtask

   task automatic t_sat();
      memw(0, 65500); memw(1, 65535); memw(2, 10); memw(3, 0);
      setup(256, 100, 0, 0);
      play("R5", 6, 256, 100, 0, 1'b0, 1'b0, 0);
      setup(256, -50, 0, 0);
      play("R5", 6, 256, -50, 0, 1'b0, 1'b0, 0);
   endtask

   task automatic t_dc();
      setup(256, 10, 3, 1234);
      play("R6", 20, 256, 10, 3, 1'b1, 1'b0, 1234);
      setup(256, 7, 1, 4000);
      play("R7", 20, 256, 7, 1, 1'b1, 1'b1, 4000);
   endtask

   // settings written mid-record apply from the next record
   task automatic t_midchange();
      int len, ofs, base;
      setup(256, 0, 3, 0);
      wr(0, 1);
      repeat (3) @(posedge clk);
      for (int n = 0; n < 800; n++) begin
         @(negedge clk);
         if (n < 256) begin len = 256; ofs = 0;   base = 0;   end
         else         begin len = 512; ofs = 500; base = 256; end
         chk("R9", "valid", int'(smp_valid), 1);
         chk("R9", "chA", int'(smp_a), model((n - base) % len, ofs, 1'b0, 1'b0, 0));
         chk("R9", "chB", int'(smp_b), model((n - base + 3) % len, ofs, 1'b0, 1'b0, 0));
         cfg_we = 1'b0;
         if (n == 100) begin cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'd500; end
         if (n == 102) begin cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 32'd512; end
      end
      wr(0, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1", "valid after disable", int'(smp_valid), 0);
   endtask

   task automatic finish_up();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      for (int a = 0; a < 1024; a++) memw(a, (a * 37 + 1000) & 16'hFFFF);
      t_basic();
      t_phase();
      t_length();
      t_sat();
      t_dc();
      t_midchange();
      done = 1'b1;
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         finish_up();
      end
   end

endmodule